// File: doc/BRIEF.md
# Link Activity and Output Enable Controller

This block watches a received video link and decides when the receiver's output pins may be driven. It runs on a free-running reference clock. It learns whether the recovered pixel clock is present by passing a toggling bit across the clock boundary. It watches the data-enable line (DE) for activity and raises a sync-detect flag once the link has shown steady line activity. The flag drops again when DE has been still for a timeout window.

The block drives three output-enable groups. The first covers pixel data, DE, the sync lines and the two upper general control outputs. The second covers the first general control output. The third covers the sync-detect output. It also drives a request that powers down the receiver core. An active-low full power-down pin removes every group and requests core power-down. An active-low output power-down pin removes only the first group, so the first control output and sync detect stay driven. Loss of the pixel clock acts like a full power-down. When the clock returns, the enables come back at once, but sync detect stays low until DE activity has been qualified again.

Top module: `lnk_act_ctl`

## Requirements
- R1: While reset is held and on the first edge after it, sync_det, oe_data, oe_ctl1 and oe_sdet are 0 and core_pd_req is 1.
- R2: With pd_n and pdo_n high and the pixel clock running, oe_data, oe_ctl1 and oe_sdet become 1 and core_pd_req becomes 0.
- R3: If the pixel clock shows no edge for CLK_WIN reference cycles, all three enables go to 0, core_pd_req goes to 1 and sync_det is cleared.
- R4: pdo_n low clears oe_data only. oe_ctl1 and oe_sdet stay 1 and core_pd_req stays 0.
- R5: pd_n low clears all three enables, sets core_pd_req and clears sync_det, whatever the level of pdo_n.
- R6: With the link active, sync_det rises only on the DE_EDGES-th falling edge of DE counted since the count was last cleared.
- R7: While sync_det is 1, it falls after DE has stayed at one level for DE_TIMEOUT reference cycles. Any DE transition restarts that window.
- R8: Every fall of sync_det clears the edge count, so a full DE_EDGES falling edges are needed to raise it again.
- R9: While sync_det is 0, a DE-idle period of DE_TIMEOUT cycles discards a partial edge count.
- R10: sync_det is never 1 in a cycle where core_pd_req is 1.
- R11: oe_data is only 1 while oe_ctl1 and oe_sdet are 1. oe_data turns on one cycle after those groups do and turns off together with them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Recovered pixel clock, may stop |
| de_in | input | 1 | Data-enable from the link decoder |
| pd_n | input | 1 | Full power-down, active low |
| pdo_n | input | 1 | Output power-down, active low |
| sync_det | output | 1 | Link qualified as active |
| oe_data | output | 1 | Enable for data, DE, sync and upper control outputs |
| oe_ctl1 | output | 1 | Enable for the first general control output |
| oe_sdet | output | 1 | Enable for the sync-detect output |
| core_pd_req | output | 1 | Request to power down the receiver core |

## Verification
The checker enforces several rules on every cycle. No group is enabled while core power-down is requested, and no sync is reported then. Data is enabled only inside the control groups, and its turn-on comes after theirs. The first control output stays enabled when data drops for an output power-down alone. A rise of sync_det must fall on a DE falling edge that follows enough earlier falling edges. Other behaviour can only be shown by the bench's scenarios. These are the exact edge count before qualification, the idle timeout and its restart on DE activity, the discard of partial counts, clock-loss detection, and recovery after the clock returns.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    // Output-enable groups plus the core power-down request.
    typedef struct packed {
        logic data;
        logic ctl1;
        logic sdet;
        logic core_pd;
    } oe_grp_t;

    localparam oe_grp_t OE_OFF = '{data: 1'b0, ctl1: 1'b0, sdet: 1'b0, core_pd: 1'b1};

endpackage

// File: rtl/lnk_sync.sv
module lnk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/lnk_clk_mon.sv
module lnk_clk_mon #(
    parameter int CLK_WIN     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pix_clk,
    output logic clk_alive
);
    localparam int CW = $clog2(CLK_WIN + 1);
    localparam logic [CW-1:0] WIN_MAX = CW'(CLK_WIN);

    // Pixel-domain toggle, flips on every pixel clock edge.
    logic tgl_q;
    always_ff @(posedge pix_clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= ~tgl_q;
    end

    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        logic [CW-1:0]        idle;
    } mon_t;

    mon_t mon_d, mon_q;
    logic seen_edge;

    always_comb begin
        mon_d     = mon_q;
        mon_d.sh  = {mon_q.sh[SYNC_STAGES-1:0], tgl_q};
        seen_edge = mon_q.sh[SYNC_STAGES] ^ mon_q.sh[SYNC_STAGES-1];
        if (seen_edge)                mon_d.idle = '0;
        else if (mon_q.idle != WIN_MAX) mon_d.idle = mon_q.idle + 1'b1;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.sh   <= '0;
            mon_q.idle <= WIN_MAX;
        end else begin
            mon_q <= mon_d;
        end
    end

    assign clk_alive = (mon_q.idle != WIN_MAX);
endmodule

// File: rtl/lnk_de_mon.sv
module lnk_de_mon #(
    parameter int DE_EDGES   = 8,
    parameter int DE_TIMEOUT = 36_000_000
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic de_s,
    input  logic clear,
    output logic sync_det,
    output logic de_fall
);
    localparam int EW = $clog2(DE_EDGES + 1);
    localparam int TW = $clog2(DE_TIMEOUT + 1);
    localparam logic [EW-1:0] EDGE_LAST = EW'(DE_EDGES - 1);
    localparam logic [TW-1:0] TMR_MAX   = TW'(DE_TIMEOUT);
    localparam logic [TW-1:0] TMR_LAST  = TW'(DE_TIMEOUT - 1);

    typedef struct packed {
        logic          prev;
        logic [EW-1:0] edges;
        logic [TW-1:0] tmr;
        logic          sync;
    } dem_t;

    dem_t dm_d, dm_q;
    logic chg, fall, expire;

    always_comb begin
        dm_d      = dm_q;
        chg       = de_s ^ dm_q.prev;
        fall      = dm_q.prev & ~de_s;
        expire    = !chg && (dm_q.tmr == TMR_LAST);
        dm_d.prev = de_s;

        if (chg)                     dm_d.tmr = '0;
        else if (dm_q.tmr != TMR_MAX) dm_d.tmr = dm_q.tmr + 1'b1;

        if (clear) begin
            dm_d.sync  = 1'b0;
            dm_d.edges = '0;
        end else if (dm_q.sync) begin
            if (expire) begin
                dm_d.sync  = 1'b0;
                dm_d.edges = '0;
            end
        end else if (expire) begin
            dm_d.edges = '0;
        end else if (fall) begin
            if (dm_q.edges == EDGE_LAST) begin
                dm_d.sync  = 1'b1;
                dm_d.edges = '0;
            end else begin
                dm_d.edges = dm_q.edges + 1'b1;
            end
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            dm_q.prev  <= 1'b0;
            dm_q.edges <= '0;
            dm_q.tmr   <= TMR_MAX;
            dm_q.sync  <= 1'b0;
        end else begin
            dm_q <= dm_d;
        end
    end

    assign sync_det = dm_q.sync;
    assign de_fall  = fall;
endmodule

// File: rtl/lnk_oe_seq.sv
module lnk_oe_seq
    import lnk_pkg::*;
(
    input  logic    ref_clk,
    input  logic    rst_n,
    input  logic    pd_s,
    input  logic    pdo_s,
    input  logic    clk_alive,
    output oe_grp_t oe
);
    oe_grp_t oe_d, oe_q;
    logic    core_on;

    always_comb begin
        core_on      = pd_s & clk_alive;
        oe_d.ctl1    = core_on;
        oe_d.sdet    = core_on;
        // Data group follows the control groups by one cycle on the way up.
        oe_d.data    = core_on & pdo_s & oe_q.ctl1;
        oe_d.core_pd = ~core_on;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) oe_q <= OE_OFF;
        else        oe_q <= oe_d;
    end

    assign oe = oe_q;
endmodule

// File: rtl/lnk_act_ctl.sv
module lnk_act_ctl
    import lnk_pkg::*;
#(
    parameter int CLK_WIN     = 1024,
    parameter int DE_EDGES    = 8,
    parameter int DE_TIMEOUT  = 36_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic de_in,
    input  logic pd_n,
    input  logic pdo_n,
    output logic sync_det,
    output logic oe_data,
    output logic oe_ctl1,
    output logic oe_sdet,
    output logic core_pd_req
);
    localparam int NSYNC = 3;

    logic [NSYNC-1:0] pins_s;
    logic             de_s, pd_s, pdo_s;
    logic             clk_alive;
    logic             de_fall;
    logic             core_clear;
    oe_grp_t          oe;

    lnk_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .din   ({de_in, pd_n, pdo_n}),
        .dout  (pins_s)
    );
    assign {de_s, pd_s, pdo_s} = pins_s;

    lnk_clk_mon #(.CLK_WIN(CLK_WIN), .SYNC_STAGES(SYNC_STAGES)) u_clk_mon (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .pix_clk   (pix_clk),
        .clk_alive (clk_alive)
    );

    assign core_clear = ~(pd_s & clk_alive);

    lnk_de_mon #(.DE_EDGES(DE_EDGES), .DE_TIMEOUT(DE_TIMEOUT)) u_de_mon (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .de_s     (de_s),
        .clear    (core_clear),
        .sync_det (sync_det),
        .de_fall  (de_fall)
    );

    lnk_oe_seq u_oe_seq (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .pd_s      (pd_s),
        .pdo_s     (pdo_s),
        .clk_alive (clk_alive),
        .oe        (oe)
    );

    assign oe_data     = oe.data;
    assign oe_ctl1     = oe.ctl1;
    assign oe_sdet     = oe.sdet;
    assign core_pd_req = oe.core_pd;
endmodule

// File: rtl/lnk_act_chk.sv
module lnk_act_chk #(
    parameter int DE_EDGES = 8
) (
    input logic ref_clk,
    input logic rst_n,
    input logic sync_det,
    input logic oe_data,
    input logic oe_ctl1,
    input logic oe_sdet,
    input logic core_pd_req,
    input logic de_fall
);
    localparam int CW = $clog2(DE_EDGES + 1);
    logic [CW-1:0] falls_q;

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)                             falls_q <= '0;
        else if (sync_det)                      falls_q <= '0;
        else if (de_fall && falls_q != CW'(DE_EDGES)) falls_q <= falls_q + 1'b1;
    end

    p_sync_needs_edges_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(sync_det) |-> ($past(de_fall) && ($past(falls_q) >= CW'(DE_EDGES - 1))));

    // R5, R3 and R10: power-down request silences every group and sync.
    p_pd_quiets_all_r10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        core_pd_req |-> (!sync_det && !oe_data && !oe_ctl1 && !oe_sdet));

    p_data_inside_ctl_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
        oe_data |-> (oe_ctl1 && oe_sdet));

    p_data_rise_late_r11: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(oe_data) |-> $past(oe_ctl1));

    p_ctl1_kept_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ($fell(oe_data) && !core_pd_req) |-> (oe_ctl1 && oe_sdet));
endmodule

bind lnk_act_ctl lnk_act_chk #(.DE_EDGES(DE_EDGES)) u_chk (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .sync_det    (sync_det),
    .oe_data     (oe_data),
    .oe_ctl1     (oe_ctl1),
    .oe_sdet     (oe_sdet),
    .core_pd_req (core_pd_req),
    .de_fall     (de_fall)
);

// File: tb/sim_lnk_act_ctl.sv
module sim_lnk_act_ctl;
    localparam int CLK_WIN    = 16;
    localparam int DE_EDGES   = 4;
    localparam int DE_TIMEOUT = 64;

    logic ref_clk = 1'b0;
    logic pix_clk = 1'b0;
    logic pix_run = 1'b0;
    logic rst_n   = 1'b0;
    logic de_in   = 1'b0;
    logic pd_n    = 1'b1;
    logic pdo_n   = 1'b1;
    logic sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req;

    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2.5 ref_clk = ~ref_clk;
    initial forever begin
        #6.5;
        if (pix_run) pix_clk = ~pix_clk;
    end

    lnk_act_ctl #(.CLK_WIN(CLK_WIN), .DE_EDGES(DE_EDGES), .DE_TIMEOUT(DE_TIMEOUT)) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .pix_clk(pix_clk), .de_in(de_in),
        .pd_n(pd_n), .pdo_n(pdo_n), .sync_det(sync_det), .oe_data(oe_data),
        .oe_ctl1(oe_ctl1), .oe_sdet(oe_sdet), .core_pd_req(core_pd_req)
    );

    // Row: {pd_n, pdo_n, clock running, exp data, exp ctl1, exp sdet, exp core_pd}
    localparam logic [6:0] VEC [7] = '{
        7'b111_1110,   // R2 all on
        7'b101_0110,   // R4 output power-down keeps ctl1/sdet
        7'b111_1110,   // R2 back on
        7'b011_0001,   // R5 full power-down
        7'b001_0001,   // R5 both low
        7'b110_0001,   // R3 clock lost
        7'b111_1110    // R2 clock back
    };

    task automatic tick(input int n);
        repeat (n) @(posedge ref_clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (sync,data,ctl1,sdet,core_pd)", req, got, exp);
        end
    endtask

    task automatic chk_sync(input string req, input logic exp);
        n_chk++;
        if (sync_det !== exp) begin
            n_fail++;
            $display("FAIL %s: sync_det got %b expected %b", req, sync_det, exp);
        end
    endtask

    task automatic de_pulse(input int half);
        de_in = 1'b1; tick(half);
        de_in = 1'b0; tick(half);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(4);
        chk("R1 in reset", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b00001);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after reset", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b00001);

        for (int i = 0; i < 7; i++) begin
            pd_n    = VEC[i][6];
            pdo_n   = VEC[i][5];
            pix_run = VEC[i][4];
            tick(60);
            chk($sformatf("R2/R3/R4/R5 row %0d", i),
                {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, {1'b0, VEC[i][3:0]});
        end

        // R6: three edges are not enough, the fourth qualifies.
        for (int k = 0; k < 3; k++) de_pulse(6);
        chk_sync("R6 three edges", 1'b0);
        de_pulse(6);
        chk_sync("R6 fourth edge", 1'b1);

        // R7: static DE times out.
        tick(40);
        chk_sync("R7 before timeout", 1'b1);
        tick(40);
        chk_sync("R7 after timeout", 1'b0);

        // R8: count was cleared by the fall.
        for (int k = 0; k < 3; k++) de_pulse(6);
        chk_sync("R8 three edges after fall", 1'b0);
        de_pulse(6);
        chk_sync("R8 requalified", 1'b1);

        // R7: slow transitions restart the window.
        de_in = 1'b1; tick(45);
        chk_sync("R7 restart high", 1'b1);
        de_in = 1'b0; tick(45);
        chk_sync("R7 restart low", 1'b1);
        tick(60);
        chk_sync("R7 idle after slow", 1'b0);

        // R9: partial count discarded by an idle gap.
        for (int k = 0; k < 3; k++) de_pulse(6);
        tick(100);
        for (int k = 0; k < 3; k++) de_pulse(6);
        chk_sync("R9 stale count dropped", 1'b0);
        de_pulse(6);
        chk_sync("R9 fresh count", 1'b1);

        // R3 and R10: clock loss clears sync; return needs requalification.
        pix_run = 1'b0;
        tick(60);
        chk("R3 clock lost with sync", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b00001);
        pix_run = 1'b1;
        tick(60);
        chk("R6 clock back unqualified", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b01110);

        // R5: full power-down clears sync.
        for (int k = 0; k < 4; k++) de_pulse(6);
        chk_sync("R6 before power-down", 1'b1);
        pd_n = 1'b0;
        tick(10);
        chk("R5 power-down clears sync", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b00001);
        pd_n = 1'b1;
        tick(10);
        chk("R5 power-up unqualified", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b01110);

        // R4: output power-down leaves sync untouched.
        for (int k = 0; k < 4; k++) de_pulse(6);
        pdo_n = 1'b0;
        tick(10);
        chk("R4 sync kept", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b10110);
        pdo_n = 1'b1;
        tick(10);
        chk("R11 data back", {sync_det, oe_data, oe_ctl1, oe_sdet, core_pd_req}, 5'b11110);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule